// File: doc/BRIEF.md
# Quad-Channel Host Bus and Interrupt Front End

This block sits between a host CPU bus and four serial channel cores. The host bus is asynchronous: an 8-bit data path, a 3-bit register offset, active-low read and write strobes, and one active-low select per channel. The block decides which channel a host access belongs to. While a read is in progress it presents that channel's register on the data bus, and otherwise it releases the bus. It converts each completed strobe into a single-cycle command pulse, in the system clock domain, on that channel's register port.

The same block also routes the four channel interrupt requests onto four interrupt pins. The default is one pin per channel. In that mode a pin is enabled either by a per-channel enable bit that the channel supplies or by a board strap that forces every pin on. Two mode bits that channel 0 supplies can fold all requests onto pin 0 as one global interrupt of selectable polarity, and that mode switches the other pins off.

Top module: `quad_host_front`

## Requirements
- R1: While `host_rd_n` is low and exactly one bit of `host_cs_n` is low, `host_doe` is 1 and `host_dout` equals the `ch_rdata` byte of that channel (channel n occupies bits 8n+7..8n). Whenever this condition does not hold, `host_doe` is 0.
- R2: If two or more bits of `host_cs_n` are low during a strobe, the bus is not driven and no channel receives a read or write pulse.
- R3: After `host_wr_n` returns high, the selected channel receives exactly one `ch_wr_stb` pulse of one cycle. During that pulse, `ch_cmd_addr` and `ch_cmd_data` hold the offset and data that were present while the strobe was low.
- R4: Each read strobe produces exactly one `ch_rd_stb` pulse of one cycle, on the selected channel, after `host_rd_n` returns high. During that pulse, `ch_cmd_addr` holds the offset of the read.
- R5: With `ch0_gint_mode`=0 and the strap low, pin n has `irq_pin_oe[n]` = `ch_irq_en[n]`. When enabled, `irq_pin[n]` = `ch_irq[n]`.
- R6: With `ch0_gint_mode`=0 and `strap_irq_always`=1, all four pins are enabled whatever the value of `ch_irq_en`, and pin n carries `ch_irq[n]`.
- R7: With `ch0_gint_mode`=1 and `ch0_gint_act_hi`=1, pin 0 is enabled and is 1 exactly when any `ch_irq` bit is 1.
- R8: With `ch0_gint_mode`=1 and `ch0_gint_act_hi`=0, pin 0 is enabled and is 0 exactly when any `ch_irq` bit is 1.
- R9: With `ch0_gint_mode`=1, `irq_pin_oe[3:1]` are 0.
- R10: During and directly after synchronous reset, no read or write pulses are issued.
- R11: In any cycle, at most one bit of `ch_wr_stb` is high, and at most one bit of `ch_rd_stb` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 3 | Register offset from host |
| host_rd_n | input | 1 | Read strobe, active low |
| host_wr_n | input | 1 | Write strobe, active low |
| host_cs_n | input | 4 | Per-channel select, active low |
| host_din | input | 8 | Data bus value seen from host |
| host_dout | output | 8 | Data bus value driven to host |
| host_doe | output | 1 | Data bus output enable |
| strap_irq_always | input | 1 | Strap forcing all individual interrupt pins on |
| ch_peek_addr | output | 3 | Live offset for channel read data lookup |
| ch_rdata | input | 32 | Read data from each channel, 8 bits each |
| ch_cmd_addr | output | 3 | Offset accompanying a command pulse |
| ch_cmd_data | output | 8 | Write data accompanying a write pulse |
| ch_wr_stb | output | 4 | Per-channel write pulse |
| ch_rd_stb | output | 4 | Per-channel read-completion pulse |
| ch_irq | input | 4 | Per-channel interrupt request |
| ch_irq_en | input | 4 | Per-channel pin enable (modem control bit) |
| ch0_gint_mode | input | 1 | Global interrupt mode from channel 0 |
| ch0_gint_act_hi | input | 1 | Global interrupt polarity from channel 0 |
| irq_pin | output | 4 | Interrupt pin levels |
| irq_pin_oe | output | 4 | Interrupt pin output enables |

## Verification
The assertions run on every clock. They check that the command pulses are one-hot and last a single cycle, that a write pulse appears only after a synchronized rising edge of the write strobe, and that the interrupt pins obey the global-mode level, polarity and disable rules and the strap override. The directed scenarios are the only place where these are shown: the asynchronous read path and its data values, the write data and offset reaching the right channel, and a select conflict suppressing both bus drive and pulses. They also show that each host strobe yields exactly one pulse, and how per-channel enables combine with the strap.

// File: rtl/quad_host_pkg.sv
// Shared constants for the quad host front end.
// Assumes four channels with byte-wide registers at eight offsets.
package quad_host_pkg;
    localparam int unsigned QH_NCH   = 4;
    localparam int unsigned QH_AW    = 3;
    localparam int unsigned QH_DW    = 8;
    localparam int unsigned QH_SYNC  = 2;
endpackage

// File: rtl/qh_strobe_sync.sv
// Synchronizes one active-low asynchronous strobe into the clock domain.
// Gives a synchronized "strobe low" level and a one-cycle pulse on the release
// (rising) edge. Assumes the strobe stays low for at least STAGES+1 clocks.
module qh_strobe_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n,
    output logic level_lo,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              prev;

    // Shift the raw strobe through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], strobe_n};
    end

    // Keep the last synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b1;
        else        prev <= chain[STAGES-1];
    end

    assign level_lo = ~chain[STAGES-1];
    assign rise     = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/qh_bus_decoder.sv
// Decodes the channel selects and builds the asynchronous read path.
// A select is valid only when exactly one select is low. The bus is driven
// only while the read strobe is low and the select is valid.
module qh_bus_decoder #(
    parameter int unsigned NCH = 4,
    parameter int unsigned DW  = 8,
    localparam int unsigned IDX_W = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int unsigned CNT_W = $clog2(NCH + 1)
) (
    input  logic [NCH-1:0]    cs_n,
    input  logic              rd_n,
    input  logic [NCH*DW-1:0] rdata,
    output logic              sel_valid,
    output logic [IDX_W-1:0]  sel_idx,
    output logic [DW-1:0]     dout,
    output logic              doe
);
    logic [CNT_W-1:0] act_cnt;

    // Count active selects and remember the index of the last one found.
    always_comb begin
        act_cnt = '0;
        sel_idx = '0;
        for (int i = 0; i < NCH; i++) begin
            if (!cs_n[i]) begin
                act_cnt = act_cnt + 1'b1;
                sel_idx = IDX_W'(i);
            end
        end
    end

    assign sel_valid = (act_cnt == CNT_W'(1));

    // Drive the selected channel's byte during a valid read, else release.
    always_comb begin
        doe  = sel_valid & ~rd_n;
        dout = doe ? rdata[sel_idx*DW +: DW] : '0;
    end
endmodule

// File: rtl/qh_xfer_ctrl.sv
// Turns synchronized host strobes into single-cycle channel command pulses.
// Captures select, offset and data while a strobe is low and fires one pulse
// on the strobe's release edge. Assumes the host holds select, offset and data
// steady until the strobe has been released for a few clocks.
module qh_xfer_ctrl #(
    parameter int unsigned NCH = 4,
    parameter int unsigned AW  = 3,
    parameter int unsigned DW  = 8,
    localparam int unsigned IDX_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_lo,
    input  logic             wr_rise,
    input  logic             rd_lo,
    input  logic             rd_rise,
    input  logic             sel_valid,
    input  logic [IDX_W-1:0] sel_idx,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    din,
    output logic [NCH-1:0]   wr_stb,
    output logic [NCH-1:0]   rd_stb,
    output logic [AW-1:0]    cmd_addr,
    output logic [DW-1:0]    cmd_data
);
    logic             cap_valid;
    logic [IDX_W-1:0] cap_idx;
    logic [AW-1:0]    cap_addr;
    logic [DW-1:0]    cap_data;

    // Capture select and offset while either strobe is active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_valid <= 1'b0;
            cap_idx   <= '0;
            cap_addr  <= '0;
        end else if (wr_lo || rd_lo) begin
            cap_valid <= sel_valid;
            cap_idx   <= sel_idx;
            cap_addr  <= addr;
        end
    end

    // Capture write data only while the write strobe is active.
    always_ff @(posedge clk) begin
        if (!rst_n)     cap_data <= '0;
        else if (wr_lo) cap_data <= din;
    end

    // Issue one pulse per released strobe to the captured channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_stb   <= '0;
            rd_stb   <= '0;
            cmd_addr <= '0;
            cmd_data <= '0;
        end else begin
            wr_stb <= '0;
            rd_stb <= '0;
            if (wr_rise && cap_valid) begin
                wr_stb[cap_idx] <= 1'b1;
                cmd_addr        <= cap_addr;
                cmd_data        <= cap_data;
            end else if (rd_rise && cap_valid) begin
                rd_stb[cap_idx] <= 1'b1;
                cmd_addr        <= cap_addr;
            end
        end
    end

    assert_wr_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_stb));
    assert_rd_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_stb));
    assert_wr_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb != '0) |=> (wr_stb == '0));
    assert_rd_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb != '0) |=> (rd_stb == '0));
    assert_wr_after_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb != '0) |-> $past(wr_rise));
endmodule

// File: rtl/qh_irq_router.sv
// Maps per-channel interrupt requests onto the interrupt pins.
// Individual mode: pin n follows request n, enabled by its channel bit or the
// strap. Global mode: pin 0 carries the OR of all requests at the chosen
// polarity and the other pins are disabled. A disabled pin drives 0 with oe=0.
module qh_irq_router #(
    parameter int unsigned NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] irq_req,
    input  logic [NCH-1:0] irq_en,
    input  logic           strap_on,
    input  logic           gint_mode,
    input  logic           gint_act_hi,
    output logic [NCH-1:0] pin_val,
    output logic [NCH-1:0] pin_oe
);
    logic any_req;

    assign any_req = |irq_req;

    for (genvar n = 0; n < NCH; n++) begin : g_pin
        if (n == 0) begin : g_head
            // Pin 0: global output in global mode, else its own channel.
            always_comb begin
                if (gint_mode) begin
                    pin_oe[n]  = 1'b1;
                    pin_val[n] = gint_act_hi ? any_req : ~any_req;
                end else begin
                    pin_oe[n]  = irq_en[n] | strap_on;
                    pin_val[n] = pin_oe[n] & irq_req[n];
                end
            end
        end else begin : g_tail
            // Other pins: own channel only when not in global mode.
            always_comb begin
                pin_oe[n]  = ~gint_mode & (irq_en[n] | strap_on);
                pin_val[n] = pin_oe[n] & irq_req[n];
            end
        end
    end

    assert_gint_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (gint_mode && gint_act_hi && (irq_req != '0)) |-> (pin_oe[0] && pin_val[0]));
    assert_gint_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (gint_mode && !gint_act_hi && (irq_req != '0)) |-> (pin_oe[0] && !pin_val[0]));
    assert_gint_others_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        gint_mode |-> (pin_oe[NCH-1:1] == '0));
    assert_strap_all_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (strap_on && !gint_mode) |-> (pin_oe == '1));
endmodule

// File: rtl/quad_host_front.sv
// Top of the quad host front end: asynchronous host bus decode, strobe
// synchronization, per-channel command pulses and interrupt pin routing.
// Assumes host select, offset and write data stay stable around each strobe.
module quad_host_front
    import quad_host_pkg::*;
#(
    parameter int unsigned NCH   = QH_NCH,
    parameter int unsigned AW    = QH_AW,
    parameter int unsigned DW    = QH_DW,
    parameter int unsigned SYNC  = QH_SYNC,
    localparam int unsigned IDX_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     host_addr,
    input  logic              host_rd_n,
    input  logic              host_wr_n,
    input  logic [NCH-1:0]    host_cs_n,
    input  logic [DW-1:0]     host_din,
    output logic [DW-1:0]     host_dout,
    output logic              host_doe,
    input  logic              strap_irq_always,
    output logic [AW-1:0]     ch_peek_addr,
    input  logic [NCH*DW-1:0] ch_rdata,
    output logic [AW-1:0]     ch_cmd_addr,
    output logic [DW-1:0]     ch_cmd_data,
    output logic [NCH-1:0]    ch_wr_stb,
    output logic [NCH-1:0]    ch_rd_stb,
    input  logic [NCH-1:0]    ch_irq,
    input  logic [NCH-1:0]    ch_irq_en,
    input  logic              ch0_gint_mode,
    input  logic              ch0_gint_act_hi,
    output logic [NCH-1:0]    irq_pin,
    output logic [NCH-1:0]    irq_pin_oe
);
    logic             wr_lo, wr_rise, rd_lo, rd_rise;
    logic             sel_valid;
    logic [IDX_W-1:0] sel_idx;

    // The channel read lookup follows the live host offset.
    assign ch_peek_addr = host_addr;

    qh_strobe_sync #(.STAGES(SYNC)) u_wr_sync (
        .clk(clk), .rst_n(rst_n), .strobe_n(host_wr_n),
        .level_lo(wr_lo), .rise(wr_rise)
    );

    qh_strobe_sync #(.STAGES(SYNC)) u_rd_sync (
        .clk(clk), .rst_n(rst_n), .strobe_n(host_rd_n),
        .level_lo(rd_lo), .rise(rd_rise)
    );

    qh_bus_decoder #(.NCH(NCH), .DW(DW)) u_dec (
        .cs_n(host_cs_n), .rd_n(host_rd_n), .rdata(ch_rdata),
        .sel_valid(sel_valid), .sel_idx(sel_idx),
        .dout(host_dout), .doe(host_doe)
    );

    qh_xfer_ctrl #(.NCH(NCH), .AW(AW), .DW(DW)) u_xfer (
        .clk(clk), .rst_n(rst_n),
        .wr_lo(wr_lo), .wr_rise(wr_rise), .rd_lo(rd_lo), .rd_rise(rd_rise),
        .sel_valid(sel_valid), .sel_idx(sel_idx),
        .addr(host_addr), .din(host_din),
        .wr_stb(ch_wr_stb), .rd_stb(ch_rd_stb),
        .cmd_addr(ch_cmd_addr), .cmd_data(ch_cmd_data)
    );

    qh_irq_router #(.NCH(NCH)) u_irq (
        .clk(clk), .rst_n(rst_n),
        .irq_req(ch_irq), .irq_en(ch_irq_en), .strap_on(strap_irq_always),
        .gint_mode(ch0_gint_mode), .gint_act_hi(ch0_gint_act_hi),
        .pin_val(irq_pin), .pin_oe(irq_pin_oe)
    );
endmodule

// File: tb/quad_host_front_tb_top.sv
// Directed bench for quad_host_front: one task per scenario.
module quad_host_front_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  host_addr = '0;
    logic        host_rd_n = 1'b1;
    logic        host_wr_n = 1'b1;
    logic [3:0]  host_cs_n = '1;
    logic [7:0]  host_din = '0;
    logic [7:0]  host_dout;
    logic        host_doe;
    logic        strap_irq_always = 1'b0;
    logic [2:0]  ch_peek_addr;
    logic [31:0] ch_rdata;
    logic [2:0]  ch_cmd_addr;
    logic [7:0]  ch_cmd_data;
    logic [3:0]  ch_wr_stb, ch_rd_stb;
    logic [3:0]  ch_irq = '0;
    logic [3:0]  ch_irq_en = '0;
    logic        ch0_gint_mode = 1'b0;
    logic        ch0_gint_act_hi = 1'b0;
    logic [3:0]  irq_pin, irq_pin_oe;

    int checks = 0;
    int fails  = 0;

    // Pulse monitor state, sampled on the falling edge.
    int         wr_cnt = 0, rd_cnt = 0, multi_cnt = 0;
    logic [3:0] last_wr_ch = '0, last_rd_ch = '0;
    logic [2:0] last_wr_addr = '0, last_rd_addr = '0;
    logic [7:0] last_wr_data = '0;

    always #5 clk = ~clk;

    // Channel model: each channel returns a distinct byte per offset.
    for (genvar g = 0; g < 4; g++) begin : g_chan
        assign ch_rdata[g*8 +: 8] = exp_rd(g, ch_peek_addr);
    end

    quad_host_front dut_i (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr),
        .host_rd_n(host_rd_n), .host_wr_n(host_wr_n), .host_cs_n(host_cs_n),
        .host_din(host_din), .host_dout(host_dout), .host_doe(host_doe),
        .strap_irq_always(strap_irq_always), .ch_peek_addr(ch_peek_addr),
        .ch_rdata(ch_rdata), .ch_cmd_addr(ch_cmd_addr), .ch_cmd_data(ch_cmd_data),
        .ch_wr_stb(ch_wr_stb), .ch_rd_stb(ch_rd_stb), .ch_irq(ch_irq),
        .ch_irq_en(ch_irq_en), .ch0_gint_mode(ch0_gint_mode),
        .ch0_gint_act_hi(ch0_gint_act_hi), .irq_pin(irq_pin), .irq_pin_oe(irq_pin_oe)
    );

    function automatic logic [7:0] exp_rd(int ch, logic [2:0] a);
        return 8'(ch * 64) ^ {5'b10100, a};
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            if ($countones(ch_wr_stb) > 1 || $countones(ch_rd_stb) > 1) multi_cnt++;
            if (ch_wr_stb != 0) begin
                wr_cnt++; last_wr_ch = ch_wr_stb;
                last_wr_addr = ch_cmd_addr; last_wr_data = ch_cmd_data;
            end
            if (ch_rd_stb != 0) begin
                rd_cnt++; last_rd_ch = ch_rd_stb; last_rd_addr = ch_cmd_addr;
            end
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        wr_cnt = 0; rd_cnt = 0;
        last_wr_ch = '0; last_rd_ch = '0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R10 wr_stb in reset", ch_wr_stb, 0);
        check("R10 rd_stb in reset", ch_rd_stb, 0);
        check("R1 doe idle", host_doe, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R10 wr_stb after reset", ch_wr_stb, 0);
        check("R10 rd_stb after reset", ch_rd_stb, 0);
    endtask

    task automatic t_read(int ch, logic [2:0] a);
        clear_mon();
        @(negedge clk);
        host_cs_n = ~(4'b1 << ch); host_addr = a; host_rd_n = 1'b0;
        #1;
        check("R1 doe during read", host_doe, 1);
        check("R1 read data", host_dout, exp_rd(ch, a));
        repeat (4) @(negedge clk);
        host_rd_n = 1'b1;
        #1;
        check("R1 doe released", host_doe, 0);
        repeat (6) @(negedge clk);
        host_cs_n = '1;
        check("R4 one read pulse", rd_cnt, 1);
        check("R4 read pulse channel", last_rd_ch, 4'b1 << ch);
        check("R4 read pulse offset", last_rd_addr, a);
        check("R2 no write on read", wr_cnt, 0);
    endtask

    task automatic t_write(int ch, logic [2:0] a, logic [7:0] d);
        clear_mon();
        @(negedge clk);
        host_cs_n = ~(4'b1 << ch); host_addr = a; host_din = d; host_wr_n = 1'b0;
        #1;
        check("R1 no drive on write", host_doe, 0);
        repeat (4) @(negedge clk);
        host_wr_n = 1'b1;
        repeat (6) @(negedge clk);
        host_cs_n = '1;
        check("R3 one write pulse", wr_cnt, 1);
        check("R3 write channel", last_wr_ch, 4'b1 << ch);
        check("R3 write offset", last_wr_addr, a);
        check("R3 write data", last_wr_data, d);
    endtask

    task automatic t_conflict(logic [3:0] cs);
        clear_mon();
        @(negedge clk);
        host_cs_n = cs; host_addr = 3'd5; host_rd_n = 1'b0;
        #1;
        check("R2 no drive on conflict", host_doe, 0);
        repeat (4) @(negedge clk);
        host_rd_n = 1'b1;
        repeat (3) @(negedge clk);
        host_din = 8'h3C; host_wr_n = 1'b0;
        repeat (4) @(negedge clk);
        host_wr_n = 1'b1;
        repeat (6) @(negedge clk);
        host_cs_n = '1;
        check("R2 no read pulse on conflict", rd_cnt, 0);
        check("R2 no write pulse on conflict", wr_cnt, 0);
    endtask

    task automatic t_irq_individual();
        ch0_gint_mode = 1'b0; strap_irq_always = 1'b0;
        ch_irq_en = 4'b0101; ch_irq = 4'b1111;
        @(negedge clk);
        check("R5 oe follows enables", irq_pin_oe, 4'b0101);
        check("R5 enabled pins carry request", irq_pin & irq_pin_oe, 4'b0101);
        ch_irq = 4'b1010; ch_irq_en = 4'b1110;
        @(negedge clk);
        check("R5 oe second pattern", irq_pin_oe, 4'b1110);
        check("R5 levels second pattern", irq_pin & irq_pin_oe, 4'b1010);
    endtask

    task automatic t_irq_strap();
        ch0_gint_mode = 1'b0; strap_irq_always = 1'b1;
        ch_irq_en = 4'b0000; ch_irq = 4'b0110;
        @(negedge clk);
        check("R6 strap enables all", irq_pin_oe, 4'b1111);
        check("R6 strap levels", irq_pin, 4'b0110);
        strap_irq_always = 1'b0;
        @(negedge clk);
        check("R5 strap low, enables off", irq_pin_oe, 4'b0000);
    endtask

    task automatic t_irq_global();
        ch0_gint_mode = 1'b1; ch0_gint_act_hi = 1'b1;
        ch_irq_en = 4'b1111; ch_irq = 4'b0010;
        @(negedge clk);
        check("R7 pin0 enabled", irq_pin_oe[0], 1);
        check("R7 active high asserted", irq_pin[0], 1);
        check("R9 other pins off", irq_pin_oe[3:1], 0);
        ch_irq = 4'b0000;
        @(negedge clk);
        check("R7 active high idle", irq_pin[0], 0);
        ch0_gint_act_hi = 1'b0;
        @(negedge clk);
        check("R8 active low idle", irq_pin[0], 1);
        ch_irq = 4'b1000; strap_irq_always = 1'b1;
        @(negedge clk);
        check("R8 active low asserted", irq_pin[0], 0);
        check("R9 strap does not revive pins", irq_pin_oe[3:1], 0);
        ch0_gint_mode = 1'b0; strap_irq_always = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        t_reset();
        for (int c = 0; c < 4; c++) begin
            t_read(c, 3'(c + 1));
            t_read(c, 3'(7 - c));
        end
        for (int c = 0; c < 4; c++) t_write(c, 3'(2 * c), 8'(8'hA5 ^ (c * 17)));
        t_conflict(4'b1100);
        t_conflict(4'b0000);
        clear_mon();
        @(negedge clk);
        host_rd_n = 1'b0;
        #1;
        check("R1 no select, no drive", host_doe, 0);
        host_rd_n = 1'b1;
        t_irq_individual();
        t_irq_strap();
        t_irq_global();
        check("R11 at most one pulse bit", multi_cnt, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule